// File: doc/BRIEF.md
# Power-Up Strap Capture and Test-Mode Controller

This block records the clock generator's frequency-select straps and its test-select strap exactly once per power cycle. The capture happens the first time the active-low power-good input is seen low after reset. From the captured bits it produces a CPU frequency code. In every valid code the SRC clock stays at 100 MHz and the PCI clock at 33.33 MHz, so only the CPU rate is encoded. The captured bits are also presented for register readback. The three-level test-select pin arrives already resolved into a "test level" flag and a logic value, so no analog detection is modelled here.

The second job of the block is the output-mode state. Test mode can be entered in two ways. A high test level on the strap at capture time enters it; in that case the real-time select-B pin chooses between high impedance and a divided reference clock. A software entry bit enters it after capture; in that case a software select bit makes the choice and the pin is ignored. Once entered, test mode is left only by a power cycle, which is modelled by the synchronous reset `rst`.

Top module: `strap_test_ctrl`

## Requirements
- R1: From reset until power-good is captured, `clk_mode` reads 0 (normal), `fs_readback` reads 000, `cpu_freq` reads the default code 4, and `freq_invalid` reads 0.
- R2: Power-good goes through a SYNC_STAGES-flop synchronizer. The straps are captured on the edge after the synchronized power-good first reads low. Later changes to the straps, to the test level, or to power-good itself have no effect on the captured values until `rst`.
- R3: With effective select bits {C,B,A}, `cpu_freq` decodes as follows: 101→0 (100 MHz), 001→1 (133.33), 011→2 (166.66), 010→3 (200), 000→4 (266.66), 100→5 (333.33), 110→6 (400).
- R4: Captured bits 111 are reserved. They set `freq_invalid` to 1 and leave `cpu_freq` at the default code 4.
- R5: `fs_readback` bit 2 holds C, bit 1 holds B and bit 0 holds A, as captured. When the test level is captured, bit 2 reads 1 and the decode uses C = 0.
- R6: When the test level is captured and software has not entered test mode, `clk_mode` follows the select-B pin in real time, after SYNC_STAGES edges of synchronization. Pin 0 gives 1 (Hi-Z) and pin 1 gives 2 (divided reference).
- R7: When `sw_test_entry` is 1 at a clock edge after capture, test mode is entered. From the next cycle `clk_mode` is 2 if `sw_refn_sel` is 1 and 1 otherwise, and the select-B pin has no effect.
- R8: When the hardware strap and software entry are both active, the software select bit decides the mode.
- R9: Once `clk_mode` is non-zero it never returns to 0 before `rst`, even if `sw_test_entry` is cleared.
- R10: `sw_test_entry` asserted before capture has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; models a power cycle |
| pwrgd_n | input | 1 | Active-low power-good; its first low level triggers the strap capture |
| strap_test_lvl | input | 1 | Resolved test-select level on the shared C strap (1 = test) |
| strap_sel_c | input | 1 | Logic value of the C strap when it is not at test level |
| strap_sel_b | input | 1 | B select strap; also the real-time mode pin in hardware test |
| strap_sel_a | input | 1 | A select strap |
| sw_test_entry | input | 1 | Software test-entry register bit |
| sw_refn_sel | input | 1 | Software mode bit (1 = divided reference, 0 = Hi-Z) |
| clk_mode | output | 2 | 0 normal, 1 Hi-Z, 2 divided reference |
| cpu_freq | output | 3 | Decoded CPU frequency code |
| freq_invalid | output | 1 | Reserved select code was captured |
| fs_readback | output | 3 | Captured select bits for register readback |

## Verification
The bench uses the default SYNC_STAGES of 2 and the default frequency code of 266.66 MHz. With these values, the capture delay and the pin-to-mode delay are both short enough that every trial can repeat the full sequence in a few dozen cycles: capture, hold against strap changes, hardware pin toggling, then software entry and release. Random strap patterns cover all eight select codes, including the reserved code, with and without the test level. Directed trials cover software entry before capture and both entry paths active at once.

// File: rtl/strap_test_pkg.sv
package strap_test_pkg;

    localparam int FS_BITS = 3;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_HIZ    = 2'd1,
        MODE_REFN   = 2'd2
    } clk_mode_e;

    typedef enum logic [2:0] {
        CPU_100 = 3'd0,
        CPU_133 = 3'd1,
        CPU_166 = 3'd2,
        CPU_200 = 3'd3,
        CPU_266 = 3'd4,
        CPU_333 = 3'd5,
        CPU_400 = 3'd6
    } cpu_freq_e;

    typedef struct packed {
        logic c;
        logic b;
        logic a;
    } fs_bits_t;

    typedef struct packed {
        logic      valid;
        cpu_freq_e code;
    } freq_dec_t;

    function automatic freq_dec_t decode_fs(input fs_bits_t fs);
        freq_dec_t r;
        r.valid = 1'b1;
        r.code  = CPU_266;
        case (fs)
            3'b000: r.code = CPU_266;
            3'b001: r.code = CPU_133;
            3'b010: r.code = CPU_200;
            3'b011: r.code = CPU_166;
            3'b100: r.code = CPU_333;
            3'b101: r.code = CPU_100;
            3'b110: r.code = CPU_400;
            default: r.valid = 1'b0;
        endcase
        return r;
    endfunction

    function automatic clk_mode_e pick_mode(input logic refn);
        return refn ? MODE_REFN : MODE_HIZ;
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/strap_latch.sv
module strap_latch
    import strap_test_pkg::*;
#(
    parameter cpu_freq_e DEFAULT_FREQ = CPU_266
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pwrgd_sync_n,
    input  logic      test_lvl,
    input  fs_bits_t  pins,
    output logic      held,
    output logic      hw_test,
    output fs_bits_t  readback,
    output cpu_freq_e freq,
    output logic      invalid
);
    fs_bits_t  eff;
    freq_dec_t dec;
    logic      capture;

    always_comb begin
        eff   = pins;
        if (test_lvl) eff.c = 1'b0;
        dec   = decode_fs(eff);
        capture = !held && !pwrgd_sync_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held     <= 1'b0;
            hw_test  <= 1'b0;
            readback <= '0;
            freq     <= DEFAULT_FREQ;
            invalid  <= 1'b0;
        end else if (capture) begin
            held       <= 1'b1;
            hw_test    <= test_lvl;
            readback.a <= pins.a;
            readback.b <= pins.b;
            readback.c <= test_lvl ? 1'b1 : pins.c;
            if (dec.valid) begin
                freq    <= dec.code;
                invalid <= 1'b0;
            end else begin
                invalid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/test_mode_ctrl.sv
module test_mode_ctrl
    import strap_test_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      held,
    input  logic      hw_test,
    input  logic      pin_sync,
    input  logic      sw_entry,
    input  logic      sw_refn,
    output logic      sw_active,
    output clk_mode_e mode
);
    always_ff @(posedge clk) begin
        if (rst)                  sw_active <= 1'b0;
        else if (held && sw_entry) sw_active <= 1'b1;
    end

    always_comb begin
        mode = MODE_NORMAL;
        if (held) begin
            if (sw_active)    mode = pick_mode(sw_refn);
            else if (hw_test) mode = pick_mode(pin_sync);
        end
    end
endmodule

// File: rtl/strap_test_ctrl.sv
module strap_test_ctrl
    import strap_test_pkg::*;
#(
    parameter int        SYNC_STAGES  = 2,
    parameter cpu_freq_e DEFAULT_FREQ = CPU_266
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwrgd_n,
    input  logic       strap_test_lvl,
    input  logic       strap_sel_c,
    input  logic       strap_sel_b,
    input  logic       strap_sel_a,
    input  logic       sw_test_entry,
    input  logic       sw_refn_sel,
    output logic [1:0] clk_mode,
    output logic [2:0] cpu_freq,
    output logic       freq_invalid,
    output logic [2:0] fs_readback
);
    localparam int SYNC_W = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

    logic      pwrgd_sync_n;
    logic      pin_sync;
    logic      held_q;
    logic      hw_test;
    logic      sw_active;
    fs_bits_t  pins;
    fs_bits_t  rb;
    cpu_freq_e freq;
    clk_mode_e mode;

    assign pins = '{c: strap_sel_c, b: strap_sel_b, a: strap_sel_a};

    strap_sync #(.STAGES(SYNC_W), .RST_VAL(1'b1)) u_pg_sync (
        .clk(clk), .rst(rst), .d(pwrgd_n), .q(pwrgd_sync_n)
    );

    strap_sync #(.STAGES(SYNC_W), .RST_VAL(1'b0)) u_pin_sync (
        .clk(clk), .rst(rst), .d(strap_sel_b), .q(pin_sync)
    );

    strap_latch #(.DEFAULT_FREQ(DEFAULT_FREQ)) u_latch (
        .clk(clk), .rst(rst), .pwrgd_sync_n(pwrgd_sync_n),
        .test_lvl(strap_test_lvl), .pins(pins),
        .held(held_q), .hw_test(hw_test), .readback(rb),
        .freq(freq), .invalid(freq_invalid)
    );

    test_mode_ctrl u_mode (
        .clk(clk), .rst(rst), .held(held_q), .hw_test(hw_test),
        .pin_sync(pin_sync), .sw_entry(sw_test_entry), .sw_refn(sw_refn_sel),
        .sw_active(sw_active), .mode(mode)
    );

    assign clk_mode    = mode;
    assign cpu_freq    = freq;
    assign fs_readback = rb;
endmodule

// File: rtl/strap_test_ctrl_chk.sv
module strap_test_ctrl_chk #(
    parameter logic [2:0] DEF_CODE = 3'd4
) (
    input logic       clk,
    input logic       rst,
    input logic       held,
    input logic       sw_active,
    input logic       sw_test_entry,
    input logic       sw_refn_sel,
    input logic [1:0] clk_mode,
    input logic [2:0] cpu_freq,
    input logic       freq_invalid,
    input logic [2:0] fs_readback
);
    a_r1_idle_before_capture: assert property (@(posedge clk) disable iff (rst)
        !held |-> (clk_mode == 2'd0 && fs_readback == 3'd0));

    a_r2_capture_holds: assert property (@(posedge clk) disable iff (rst)
        held |=> ($stable(fs_readback) && $stable(cpu_freq) && $stable(freq_invalid)));

    a_r4_reserved_keeps_default: assert property (@(posedge clk) disable iff (rst)
        freq_invalid |-> cpu_freq == DEF_CODE);

    a_r8_sw_select_wins: assert property (@(posedge clk) disable iff (rst)
        sw_active |-> clk_mode == (sw_refn_sel ? 2'd2 : 2'd1));

    a_r9_test_sticky: assert property (@(posedge clk) disable iff (rst)
        (clk_mode != 2'd0) |=> (clk_mode != 2'd0));

    a_r10_early_entry_ignored: assert property (@(posedge clk) disable iff (rst)
        (!held && sw_test_entry) |=> !sw_active);

    a_r7_entry_takes_effect: assert property (@(posedge clk) disable iff (rst)
        (held && sw_test_entry) |=> sw_active);
endmodule

bind strap_test_ctrl strap_test_ctrl_chk #(.DEF_CODE(DEFAULT_FREQ)) u_chk (
    .clk(clk), .rst(rst), .held(held_q), .sw_active(sw_active),
    .sw_test_entry(sw_test_entry), .sw_refn_sel(sw_refn_sel),
    .clk_mode(clk_mode), .cpu_freq(cpu_freq), .freq_invalid(freq_invalid),
    .fs_readback(fs_readback)
);

// File: tb/tb_strap_test_ctrl.sv
module tb_strap_test_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwrgd_n = 1'b1;
    logic       strap_test_lvl = 1'b0;
    logic       strap_sel_c = 1'b0;
    logic       strap_sel_b = 1'b0;
    logic       strap_sel_a = 1'b0;
    logic       sw_test_entry = 1'b0;
    logic       sw_refn_sel = 1'b0;
    logic [1:0] clk_mode;
    logic [2:0] cpu_freq;
    logic       freq_invalid;
    logic [2:0] fs_readback;

    int n_total = 0;
    int n_bad   = 0;

    always #5 clk = ~clk;

    strap_test_ctrl dut (
        .clk(clk), .rst(rst), .pwrgd_n(pwrgd_n),
        .strap_test_lvl(strap_test_lvl), .strap_sel_c(strap_sel_c),
        .strap_sel_b(strap_sel_b), .strap_sel_a(strap_sel_a),
        .sw_test_entry(sw_test_entry), .sw_refn_sel(sw_refn_sel),
        .clk_mode(clk_mode), .cpu_freq(cpu_freq),
        .freq_invalid(freq_invalid), .fs_readback(fs_readback)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input bit c, input bit b, input bit a, input bit t);
        bit [2:0] k;
        k = {(t ? 1'b0 : c), b, a};
        case (k)
            3'b101: return 0;
            3'b001: return 1;
            3'b011: return 2;
            3'b010: return 3;
            3'b000: return 4;
            3'b100: return 5;
            3'b110: return 6;
            default: return 4;
        endcase
    endfunction

    function automatic int exp_inv(input bit c, input bit b, input bit a, input bit t);
        return (!t && c && b && a) ? 1 : 0;
    endfunction

    task automatic power_cycle(input bit c, input bit b, input bit a, input bit t);
        rst = 1'b1; pwrgd_n = 1'b1; sw_test_entry = 1'b0; sw_refn_sel = 1'b0;
        strap_sel_c = c; strap_sel_b = b; strap_sel_a = a; strap_test_lvl = t;
        tick(2);
        rst = 1'b0;
        tick(1);
        check("R1 mode", clk_mode, 0);
        check("R1 readback", fs_readback, 0);
        check("R1 freq", cpu_freq, 4);
        check("R1 invalid", freq_invalid, 0);
    endtask

    task automatic trial(input bit c, input bit b, input bit a, input bit t,
                         input bit use_sw, input bit refn);
        int rb_exp;
        power_cycle(c, b, a, t);
        pwrgd_n = 1'b0;
        tick(4);
        rb_exp = {(t ? 1'b1 : c), b, a};
        check("R5 readback", fs_readback, rb_exp);
        check("R3 freq", cpu_freq, exp_code(c, b, a, t));
        check("R4 invalid", freq_invalid, exp_inv(c, b, a, t));
        check("R6 mode after capture", clk_mode, t ? (b ? 2 : 1) : 0);
        // R2: disturb everything except the live pin
        strap_sel_c = ~c; strap_sel_a = ~a; strap_test_lvl = ~t;
        pwrgd_n = 1'b1; tick(3); pwrgd_n = 1'b0; tick(4);
        check("R2 readback held", fs_readback, rb_exp);
        check("R2 freq held", cpu_freq, exp_code(c, b, a, t));
        check("R2 mode held", clk_mode, t ? (b ? 2 : 1) : 0);
        if (t) begin
            strap_sel_b = ~b; tick(3);
            check("R6 pin follow", clk_mode, (!b) ? 2 : 1);
            strap_sel_b = b; tick(3);
            check("R6 pin back", clk_mode, b ? 2 : 1);
        end
        if (use_sw) begin
            sw_refn_sel = refn; sw_test_entry = 1'b1; tick(1);
            check(t ? "R8 sw over strap" : "R7 sw entry", clk_mode, refn ? 2 : 1);
            strap_sel_b = ~strap_sel_b; tick(3);
            check("R7 pin ignored", clk_mode, refn ? 2 : 1);
            sw_test_entry = 1'b0; sw_refn_sel = ~refn; tick(2);
            check("R9 stays in test", clk_mode, (!refn) ? 2 : 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4242);
        // R10: software entry before capture is ignored
        power_cycle(1'b0, 1'b1, 1'b0, 1'b0);
        sw_test_entry = 1'b1; sw_refn_sel = 1'b1; tick(3);
        check("R10 early entry", clk_mode, 0);
        sw_test_entry = 1'b0; tick(1);
        pwrgd_n = 1'b0; tick(4);
        check("R10 after capture", clk_mode, 0);
        check("R3 code 010", cpu_freq, 3);
        // R4 directed reserved code
        trial(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        // R8 both entry paths, with pin opposite to software choice
        trial(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        trial(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        // R3 every code without test level
        for (int k = 0; k < 8; k++)
            trial(k[2], k[1], k[0], 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 30; i++) begin
            bit [5:0] r;
            r = 6'($urandom());
            trial(r[0], r[1], r[2], r[3], r[4], r[5]);
        end
        // R9 reset leaves test mode
        rst = 1'b1; tick(2); rst = 1'b0; tick(1);
        check("R9 reset exit", clk_mode, 0);
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule